// File: doc/BRIEF.md
# Seven-to-one double-edge lane deserializer

This block receives a source-synchronous link with three serial data lanes and a slow forwarded frame clock. A fast bit clock runs at seven times the frame rate and samples every lane on both of its edges. The block collects seven bits per lane for each frame. It then emits one 21-bit parallel word with a one-cycle valid strobe.

Seven is odd, so one frame covers three and a half fast cycles, and successive frames start on opposite clock edges. The block keeps a two-frame bit history per lane and tracks how many new bits lie beyond the last frame boundary. With that count it picks the seven-bit window for each word. The frame clock is sampled as a fourth lane. Its first low-to-high step after reset fixes the initial boundary. After that, a bitslip input moves the boundary one bit at a time for alignment training.

Top module: `lvds7_deser`

## Requirements
- R1: Every lane, the frame lane included, is sampled on both the rising and the falling edge of `clk`. Each fast cycle therefore contributes two consecutive serial bits, and no sample is dropped or repeated.
- R2: Within each 7-bit lane field, the first-received bit sits in the most significant position. `word_out[20:14]` carries lane 2, `word_out[13:7]` carries lane 1 and `word_out[6:0]` carries lane 0.
- R3: Without bitslip, consecutive words cover contiguous 7-bit stretches of each lane's stream with no gap and no overlap. The spacing between valid strobes alternates between 4 and 3 fast cycles, because frame starts alternate between edges.
- R4: After reset, the first serial bit at which `frame_in` is 1 after having been 0 is taken as the first bit of a frame.
- R5: The two complete frames that follow the lock point produce no valid strobe. The first word presented is the third frame.
- R6: `word_valid` is high for exactly one cycle per frame and is never high in two adjacent cycles.
- R7: For each cycle in which `bitslip` is high, one serial bit is discarded. The next word therefore starts one bit later than it would have; a pulse held for n cycles discards n bits.
- R8: Once locked, further transitions on `frame_in` have no effect on alignment. Only `bitslip` moves the boundary.
- R9: A low `rst_n` at a rising edge clears `word_valid` and `word_out` to zero and drops the lock. Until the link locks again, no word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, seven times the frame rate, both edges used |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_in | input | 3 | Serial data lanes, one bit per clock edge |
| frame_in | input | 1 | Forwarded frame clock, sampled as an extra lane |
| bitslip | input | 1 | Discards one serial bit per high cycle |
| word_out | output | 21 | Assembled frame word, lane 2 in the top field |
| word_valid | output | 1 | One-cycle strobe marking a new word_out |

## Verification
On every cycle, the assertions check that the strobe never lasts two cycles, that no word appears before the lock or changes the output before it, that the bit-count tracker stays under one frame, and that the selected window offset only takes the two edge-parity values. The exact content of each word cannot be shown by a property. That covers edge interleaving, bit order inside a field, placement of the lock point on either clock edge, the two-frame hold-off, and the one-bit shift caused by each slip cycle. The bench shows these by comparing every word against a window of the bit stream it drove itself. It runs scenarios with frames starting on each edge parity, directed and random slip pulses, and a reset in mid-stream.

// File: rtl/lvds7_pkg.sv
// Shared defaults and helpers for the seven-to-one deserializer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package lvds7_pkg;
    localparam int DFLT_LANES = 3;
    localparam int DFLT_BITS  = 7;
    localparam int HOLD_WORDS = 2;

    // Width of a counter that must hold values up to bits+1.
    function automatic int fill_width(input int bits);
        return $clog2(bits + 2);
    endfunction

    // Width of a window offset into a two-frame history.
    function automatic int offset_width(input int bits);
        return $clog2(bits + 1);
    endfunction
endpackage

// File: rtl/lvds7_ddr_capture.sv
// Double-edge input capture for a group of serial pins.
// Each pin is sampled on the rising edge into early_bit and on the
// falling edge into late_bit. At the next rising edge the pair
// {early_bit, late_bit} holds two consecutive serial bits, earliest first.
// Assumes: pins are stable around both edges of clk.
module lvds7_ddr_capture #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] early_bit,
    output logic [WIDTH-1:0] late_bit
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_pin
            // Rising-edge sample of one pin.
            always_ff @(posedge clk) begin
                if (!rst_n) early_bit[g] <= 1'b0;
                else        early_bit[g] <= pins[g];
            end

            // Falling-edge sample of the same pin.
            always_ff @(negedge clk) begin
                if (!rst_n) late_bit[g] <= 1'b0;
                else        late_bit[g] <= pins[g];
            end
        end
    endgenerate
endmodule

// File: rtl/lvds7_lane_history.sv
// Per-lane shift history, two frames deep, with window extraction.
// Two bits enter per cycle; the newest sits at bit 0. The window
// returned is taken from the history as it will look after this
// cycle's shift, so the caller can register it on the same edge.
// Window field of lane l sits at [l*BITS +: BITS], oldest bit at MSB.
// Assumes: offset + BITS never exceeds the history depth.
module lvds7_lane_history #(
    parameter int LANES = 3,
    parameter int BITS  = 7,
    parameter int OW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      early_bit,
    input  logic [LANES-1:0]      late_bit,
    input  logic [OW-1:0]         offset,
    output logic [LANES*BITS-1:0] window
);
    localparam int DEPTH = 2 * BITS;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [DEPTH-1:0] hist_q;
            logic [DEPTH-1:0] hist_n;

            // Next history: shift in the earlier bit, then the later one.
            always_comb hist_n = {hist_q[DEPTH-3:0], early_bit[g], late_bit[g]};

            // History register.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= hist_n;
            end

            // Select this lane's frame window, first-received bit on top.
            always_comb window[g*BITS +: BITS] = hist_n[offset +: BITS];
        end
    endgenerate
endmodule

// File: rtl/lvds7_boundary_track.sv
// Frame-boundary tracker. Before lock it watches the frame-clock lane
// for a 0-to-1 step between consecutive serial bits. After lock it
// counts the bits that lie beyond the last frame end. When that count
// reaches BITS a frame is complete, and the excess gives the window
// offset (0 or 1, alternating with the edge parity). Each bitslip
// cycle counts one bit fewer, which discards one serial bit.
// Assumes: the frame lane is low for at least one bit before its first rise.
module lvds7_boundary_track
    import lvds7_pkg::*;
#(
    parameter int BITS = 7,
    parameter int FW   = 4,
    parameter int OW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_early,
    input  logic          frm_late,
    input  logic          slip,
    output logic          emit,
    output logic          present,
    output logic [OW-1:0] offset,
    output logic          locked
);
    localparam int HW = $clog2(HOLD_WORDS + 1);

    logic [FW-1:0] fill_q;
    logic [FW-1:0] fill_sum;
    logic [HW-1:0] hold_q;
    logic          prev_q;

    // Bits beyond the last frame end once this cycle's pair is in.
    always_comb begin
        fill_sum = fill_q + FW'(2) - FW'(slip);
        emit     = locked && (fill_sum >= FW'(BITS));
        offset   = OW'(fill_sum - FW'(BITS));
        present  = emit && (hold_q == '0);
    end

    // Lock search, bit accounting and hold-off after lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            fill_q <= '0;
            hold_q <= HW'(HOLD_WORDS);
            prev_q <= 1'b0;
        end else begin
            prev_q <= frm_late;
            if (!locked) begin
                if (!prev_q && frm_early) begin
                    locked <= 1'b1;
                    fill_q <= FW'(2);
                end else if (!frm_early && frm_late) begin
                    locked <= 1'b1;
                    fill_q <= FW'(1);
                end
            end else begin
                fill_q <= emit ? (fill_sum - FW'(BITS)) : fill_sum;
                if (emit && hold_q != '0) hold_q <= hold_q - HW'(1);
            end
        end
    end

    // R3: after a frame is taken, fewer than BITS bits remain pending.
    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (fill_q < FW'(BITS)));

    // R3: a completed frame ends on the newest or the second-newest bit.
    a_r3_offset_parity: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (offset <= OW'(1)));
endmodule

// File: rtl/lvds7_deser.sv
// Top of the seven-to-one double-edge deserializer. Data lanes and the
// frame clock share one capture stage. Data lanes feed the history and
// window logic, and the frame lane feeds the boundary tracker. The word
// and its strobe are registered on the edge that completes a frame.
// Assumes: clk is phase-aligned to the incoming frame clock.
module lvds7_deser
    import lvds7_pkg::*;
#(
    parameter int LANES = DFLT_LANES,
    parameter int BITS  = DFLT_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      lane_in,
    input  logic                  frame_in,
    input  logic                  bitslip,
    output logic [LANES*BITS-1:0] word_out,
    output logic                  word_valid
);
    localparam int FW = fill_width(BITS);
    localparam int OW = offset_width(BITS);

    logic [LANES:0]          early_bit;
    logic [LANES:0]          late_bit;
    logic [LANES*BITS-1:0]   window;
    logic [OW-1:0]           offset;
    logic                    emit;
    logic                    present;
    logic                    trk_locked;

    lvds7_ddr_capture #(.WIDTH(LANES + 1)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     ({frame_in, lane_in}),
        .early_bit(early_bit),
        .late_bit (late_bit)
    );

    lvds7_lane_history #(.LANES(LANES), .BITS(BITS), .OW(OW)) u_history (
        .clk      (clk),
        .rst_n    (rst_n),
        .early_bit(early_bit[LANES-1:0]),
        .late_bit (late_bit[LANES-1:0]),
        .offset   (offset),
        .window   (window)
    );

    lvds7_boundary_track #(.BITS(BITS), .FW(FW), .OW(OW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_early(early_bit[LANES]),
        .frm_late (late_bit[LANES]),
        .slip     (bitslip),
        .emit     (emit),
        .present  (present),
        .offset   (offset),
        .locked   (trk_locked)
    );

    // Output word register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= present;
            if (present) word_out <= window;
        end
    end

    // R6: the strobe lasts a single cycle per frame.
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R5: a word can only appear once the boundary is locked.
    a_r5_valid_locked: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> trk_locked);

    // R9: the outputs stay cleared until the link locks.
    a_r9_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_locked |-> (word_out == '0 && !word_valid));
endmodule

// File: tb/test_lvds7_deser.sv
`timescale 1ns/1ps
// Bench: drives a random serial stream on three lanes plus a framed
// clock lane. Every word is compared to the 7-bit window of the stream
// the bench expects, computed from the lock point and the slips it drove.
module test_lvds7_deser;
    localparam int LANES = 3;
    localparam int BITS  = 7;
    localparam int MAXB  = 4096;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [LANES-1:0]      lane_in = '0;
    logic                  frame_in = 1'b0;
    logic                  bitslip = 1'b0;
    logic [LANES*BITS-1:0] word_out;
    logic                  word_valid;

    lvds7_deser #(.LANES(LANES), .BITS(BITS)) i_lvds7_deser (
        .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .frame_in(frame_in),
        .bitslip(bitslip), .word_out(word_out), .word_valid(word_valid)
    );

    always #4 clk = ~clk;

    logic [LANES-1:0] dat [MAXB];
    int  start_idx;
    int  bidx;
    bit  drive_en;
    bit  obs_en;
    int  n_checks;
    int  n_fail;
    int  nvalid;
    int  slip_cnt;
    int  slip_used;
    int  exp_start;
    int  cyc;
    int  last_cyc;
    int  last_gap;
    bit  gap_clean;
    bit  done;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic frame_bit(input int idx);
        if (idx < start_idx) return 1'b0;
        return (((idx - start_idx) % BITS) < 4);
    endfunction

    // R2: lane l field at [l*7 +: 7], first-received bit on top.
    function automatic logic [LANES*BITS-1:0] exp_word(input int s);
        logic [LANES*BITS-1:0] w;
        for (int l = 0; l < LANES; l++)
            for (int k = 0; k < BITS; k++)
                w[l*BITS + BITS-1-k] = dat[s + k][l];
        return w;
    endfunction

    // Serial driver: one new bit after each clock edge, before the next.
    initial begin
        forever begin
            @(posedge clk or negedge clk);
            #1;
            if (drive_en && bidx < MAXB) begin
                lane_in  = dat[bidx];
                frame_in = frame_bit(bidx);
                bidx++;
            end else begin
                lane_in  = '0;
                frame_in = 1'b0;
            end
        end
    end

    // Count slip cycles as the design samples them.
    always @(posedge clk) if (obs_en && bitslip) slip_cnt++;

    // Word checker, sampling after each rising edge.
    always @(negedge clk) begin
        if (obs_en) begin
            cyc++;
            if (word_valid) begin
                int pend;
                int gap;
                pend = slip_cnt - slip_used;
                slip_used = slip_cnt;
                gap = cyc - last_cyc;
                if (nvalid == 0) begin
                    exp_start = start_idx + 2*BITS;
                    // R4 R5: lock on the first rising frame bit, two frames withheld.
                    chk(word_out == exp_word(exp_start), "R4 R5 first word",
                        32'(word_out), 32'(exp_word(exp_start)));
                end else begin
                    exp_start = exp_start + BITS + pend;
                    // R1 R2 R7 R8: contiguous stream windows, slips discard bits.
                    chk(word_out == exp_word(exp_start), "R1 R2 R7 R8 word",
                        32'(word_out), 32'(exp_word(exp_start)));
                    if (pend == 0 && gap_clean && nvalid >= 2)
                        // R3 R6: strobes every 3 or 4 cycles, alternating.
                        chk((gap == 3 || gap == 4) && gap != last_gap, "R3 R6 spacing",
                            32'(gap), 32'(7 - last_gap));
                end
                gap_clean = (pend == 0);
                last_gap  = gap;
                last_cyc  = cyc;
                nvalid++;
            end
        end
    end

    task automatic start_scenario(input int s);
        @(negedge clk);
        rst_n    = 1'b0;
        obs_en   = 1'b0;
        drive_en = 1'b0;
        @(negedge clk);
        // R9: reset clears the outputs.
        chk(!word_valid && word_out == '0, "R9 reset state",
            {word_valid, 10'd0, word_out}, 32'd0);
        for (int i = 0; i < MAXB; i++) dat[i] = LANES'($urandom);
        start_idx = s;
        bidx = 0; nvalid = 0; slip_cnt = 0; slip_used = 0;
        cyc = 0; last_cyc = 0; last_gap = 0; gap_clean = 1'b0;
        drive_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        obs_en = 1'b1;
    endtask

    task automatic wait_words(input int n);
        int target;
        target = nvalid + n;
        while (nvalid < target) @(negedge clk);
    endtask

    task automatic pulse_slip(input int len);
        @(negedge clk);
        #1 bitslip = 1'b1;
        repeat (len) @(negedge clk);
        #1 bitslip = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Frames starting on one edge parity, then directed slips.
        start_scenario(21);
        // R9: no word before the lock and hold-off.
        repeat (4) @(negedge clk);
        chk(nvalid == 0, "R9 no early word", 32'(nvalid), 32'd0);
        wait_words(12);
        pulse_slip(1); wait_words(4);
        pulse_slip(2); wait_words(4);
        pulse_slip(3); wait_words(6);
        // Reset mid-stream, frames on the other parity.
        start_scenario(24);
        wait_words(15);
        for (int i = 0; i < 25; i++) begin
            repeat ($urandom_range(0, 9)) @(negedge clk);
            pulse_slip($urandom_range(1, 2));
            wait_words($urandom_range(1, 3));
        end
        wait_words(6);
        start_scenario(30);
        wait_words(10);
        chk(1'b1, "R3 end", 32'd0, 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", nvalid);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule